// File: doc/BRIEF.md
# Scancode to Button Line Mapper

This block turns a stream of keyboard scancode bytes into eight active-low output lines. Four of the lines act as push buttons. The other four stand in for two rotary wheels, a volume wheel and a navigation wheel. Each wheel has a step line and a direction line.

One byte value is a prefix. It marks the byte that follows as an extended code. The top bit of every other byte is a release flag, and the low seven bits carry the key code. The block remembers which lines are held down. A second press of a push button that is already held does nothing. A second press of a wheel key produces a fresh pulse on the wheel lines: they go high for one clock cycle and then low again.

Bytes arrive with a one-cycle valid strobe. A byte may arrive on any cycle. All outputs are registered.

Top module: `scancode_line_mapper`

## Requirements
- R1: A synchronous active-high reset drives every output line high (released). It also clears the held state of every line and the pending-extended flag.
- R2: A valid byte equal to 0xE0 sets the pending-extended flag for the next valid byte. The 0xE0 byte leaves the output lines unchanged.
- R3: For every other valid byte, bit 7 is the release flag and bits 6:0 are the key code. Each line the key maps to takes the value of the release flag: 0 for a press, 1 for a release. This value appears on the output one clock edge after the byte is captured.
- R4: Extended codes map to these lines:
  - 0x48 drives lines_n[2] and lines_n[3].
  - 0x50 drives lines_n[2] only.
  - 0x4B drives lines_n[0] and lines_n[1].
  - 0x4D drives lines_n[0] only.
- R5: Plain (non-extended) codes map to these lines:
  - 0x0F drives lines_n[4].
  - 0x32 drives lines_n[5].
  - 0x1C drives lines_n[6].
  - 0x21 drives lines_n[7].
- R6: A press of a plain key whose line is already held leaves the outputs and the held state unchanged.
- R7: A press of an extended key where any of its lines is already held drives those lines high for exactly one cycle and then low.
- R8: The pending-extended flag clears once the byte after the prefix has been processed. After that, an extended code value without a prefix is decoded as a plain code.
- R9: A code with no mapping in the current (plain or extended) table changes neither the outputs nor the held state.
- R10: A release clears the held state of its lines, so the next press of the same key acts as a fresh press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking in_byte as a new scancode byte |
| in_byte | input | BYTE_W (8) | Scancode byte: prefix, or release flag plus key code |
| lines_n | output | LINES (8) | Active-low button and wheel lines |

## Verification
A press or release appears on lines_n one clock edge after the byte is captured. The bench drives each byte at a falling edge, holds it for one cycle, and samples the lines at the next falling edge. For a wheel re-pulse, the high phase is checked at that same sample point. The low phase is checked one falling edge later, which is the cycle the pending register resolves. A prefix byte, an unknown code or a suppressed button repeat must leave lines_n unchanged at the same sample point. The bench checks this against the value it expects to be held.

// File: rtl/klm_pkg.sv
`timescale 1ns/1ps
package klm_pkg;
  // Byte that flags the following byte as an extended code.
  localparam int unsigned PREFIX_CODE = 32'hE0;

  // Extended (wheel) key codes.
  localparam int unsigned K_NAV_UP    = 32'h48;
  localparam int unsigned K_NAV_DOWN  = 32'h50;
  localparam int unsigned K_VOL_LEFT  = 32'h4B;
  localparam int unsigned K_VOL_RIGHT = 32'h4D;

  // Plain (push button) key codes.
  localparam int unsigned K_BTN_A = 32'h0F;
  localparam int unsigned K_BTN_B = 32'h32;
  localparam int unsigned K_BTN_C = 32'h1C;
  localparam int unsigned K_BTN_D = 32'h21;

  // Output line positions.
  localparam int unsigned L_VOL_STEP = 0;
  localparam int unsigned L_VOL_DIR  = 1;
  localparam int unsigned L_NAV_STEP = 2;
  localparam int unsigned L_NAV_DIR  = 3;
  localparam int unsigned L_BTN_A    = 4;
  localparam int unsigned L_BTN_B    = 5;
  localparam int unsigned L_BTN_C    = 6;
  localparam int unsigned L_BTN_D    = 7;
endpackage

// File: rtl/klm_prefix.sv
`timescale 1ns/1ps
module klm_prefix #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              is_prefix,
  output logic              ext_q
);
  import klm_pkg::*;

  assign is_prefix = (in_byte == BYTE_W'(PREFIX_CODE));

  // Every valid byte rewrites the flag: a prefix sets it, anything else consumes it.
  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else if (in_valid) ext_q <= is_prefix;
  end

  // R2: a captured prefix arms the flag for the next byte
  p_prefix_arms_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_prefix |=> ext_q);

  // R8: any non-prefix byte leaves the flag cleared
  p_ext_consumed_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_prefix |=> !ext_q);

  // R8: without a valid byte the flag holds its value
  p_ext_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ext_q));
endmodule

// File: rtl/klm_decode.sv
`timescale 1ns/1ps
module klm_decode #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned LINES  = 8
) (
  input  logic              ext,
  input  logic [CODE_W-1:0] key,
  output logic [LINES-1:0]  mask,
  output logic              wheel
);
  import klm_pkg::*;

  always_comb begin
    mask  = '0;
    wheel = ext;
    if (ext) begin
      case (key)
        CODE_W'(K_NAV_UP):    begin mask[L_NAV_STEP] = 1'b1; mask[L_NAV_DIR] = 1'b1; end
        CODE_W'(K_NAV_DOWN):  mask[L_NAV_STEP] = 1'b1;
        CODE_W'(K_VOL_LEFT):  begin mask[L_VOL_STEP] = 1'b1; mask[L_VOL_DIR] = 1'b1; end
        CODE_W'(K_VOL_RIGHT): mask[L_VOL_STEP] = 1'b1;
        default:              mask = '0;
      endcase
    end else begin
      case (key)
        CODE_W'(K_BTN_A): mask[L_BTN_A] = 1'b1;
        CODE_W'(K_BTN_B): mask[L_BTN_B] = 1'b1;
        CODE_W'(K_BTN_C): mask[L_BTN_C] = 1'b1;
        CODE_W'(K_BTN_D): mask[L_BTN_D] = 1'b1;
        default:          mask = '0;
      endcase
    end
  end
endmodule

// File: rtl/klm_lines.sv
`timescale 1ns/1ps
module klm_lines #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic             ev_release,
  input  logic             ev_wheel,
  input  logic [LINES-1:0] ev_mask,
  output logic [LINES-1:0] lines_n
);
  logic [LINES-1:0] held;
  logic [LINES-1:0] pend;
  logic             act, overlap, drop, pulse, apply;

  assign act     = ev_valid && (ev_mask != '0);
  assign overlap = (held & ev_mask) != '0;
  assign drop    = act && !ev_release && !ev_wheel && overlap;
  assign pulse   = act && !ev_release &&  ev_wheel && overlap;
  assign apply   = act && !drop;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic line_q, held_q, pend_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q <= 1'b1;
        held_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pulse && ev_mask[i];
        if (apply && ev_mask[i]) begin
          line_q <= pulse ? 1'b1 : ev_release;
          held_q <= !ev_release;
        end else if (pend_q) begin
          line_q <= 1'b0;
        end
      end
    end
    assign lines_n[i] = line_q;
    assign held[i]    = held_q;
    assign pend[i]    = pend_q;
  end

  // R2: with no event and no pending pulse the lines hold
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ev_valid && pend == '0 |=> $stable(lines_n));

  // R3: a release drives every mapped line high
  p_release_high_r3: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_release && ev_mask != '0 |=> (lines_n & $past(ev_mask)) == $past(ev_mask));

  // R6: repeated button press changes nothing
  p_button_repeat_r6: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_release && !ev_wheel && overlap && pend == '0
    |=> $stable(lines_n) && $stable(held));

  // R7: a repeated wheel press first raises its lines
  p_pulse_high_r7: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_release && ev_wheel && overlap
    |=> (lines_n & $past(ev_mask)) == $past(ev_mask));

  // R7: the pending lines fall on the following cycle
  p_pulse_low_r7: assert property (@(posedge clk) disable iff (rst)
    pend != '0 && !ev_valid |=> (lines_n & $past(pend)) == '0);

  // R9: an unmapped code leaves lines and held state alone
  p_unknown_r9: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_mask == '0 && pend == '0 |=> $stable(lines_n) && $stable(held));
endmodule

// File: rtl/scancode_line_mapper.sv
`timescale 1ns/1ps
module scancode_line_mapper #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [LINES-1:0]  lines_n
);
  localparam int unsigned CODE_W = BYTE_W - 1;

  logic             is_prefix, ext_q, wheel;
  logic [LINES-1:0] mask;

  klm_prefix #(.BYTE_W(BYTE_W)) u_prefix (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .is_prefix (is_prefix),
    .ext_q     (ext_q)
  );

  klm_decode #(.CODE_W(CODE_W), .LINES(LINES)) u_decode (
    .ext   (ext_q),
    .key   (in_byte[CODE_W-1:0]),
    .mask  (mask),
    .wheel (wheel)
  );

  klm_lines #(.LINES(LINES)) u_lines (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (in_valid && !is_prefix),
    .ev_release (in_byte[BYTE_W-1]),
    .ev_wheel   (wheel),
    .ev_mask    (mask),
    .lines_n    (lines_n)
  );
endmodule

// File: tb/test_scancode_line_mapper.sv
`timescale 1ns/1ps
module test_scancode_line_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] lines_n;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;   // 100 MHz

  scancode_line_mapper i_scancode_line_mapper (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .lines_n  (lines_n)
  );

  // {byte, expected lines_n after the byte, requirement number}
  // Tags: R2 prefix, R3 release, R4 extended map, R5 plain map,
  // R8 flag consumed, R9 unknown code, R10 release then re-press.
  localparam int NV = 30;
  localparam logic [23:0] VEC [0:NV-1] = '{
    24'h0F_EF_05, 24'h1C_AF_05, 24'h21_2F_05, 24'h32_0F_05,
    24'h8F_1F_03, 24'hA1_9F_03, 24'hB2_BF_03, 24'h9C_FF_03,
    24'hE0_FF_02, 24'h48_F3_04, 24'hE0_F3_02, 24'h4B_F0_04,
    24'hE0_F0_02, 24'hC8_FC_03, 24'hE0_FC_02, 24'hCB_FF_03,
    24'hE0_FF_02, 24'h50_FB_04, 24'hE0_FB_02, 24'hD0_FF_03,
    24'hE0_FF_02, 24'h4D_FE_04, 24'hE0_FE_02, 24'hCD_FF_03,
    24'h48_FF_08, 24'h55_FF_09, 24'hE0_FF_02, 24'h0F_FF_09,
    24'h0F_EF_08, 24'h8F_FF_0A
  };

  task automatic check(input logic [7:0] exp, input int req, input string what);
    n_cmp++;
    if (lines_n !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: lines_n=%h expected=%h", req, what, lines_n, exp);
    end
  endtask

  // Byte driven at a falling edge, captured at the rising edge,
  // result visible at the next falling edge where the task returns.
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    check(8'hFF, 1, "reset state all released");   // R1

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][23:16]);
      check(VEC[k][15:8], int'(VEC[k][7:0]), $sformatf("vector %0d byte %h", k, VEC[k][23:16]));
    end

    // R6: repeated plain press is ignored
    send(8'h1C); check(8'hBF, 6, "first press btn C");
    send(8'h1C); check(8'hBF, 6, "repeat press btn C ignored");
    step();      check(8'hBF, 6, "repeat press no later change");
    send(8'h9C); check(8'hFF, 6, "release after ignored repeat");

    // R7: repeated wheel press re-pulses
    send(8'hE0); send(8'h48); check(8'hF3, 7, "nav up first press");
    send(8'hE0); send(8'h48); check(8'hFF, 7, "nav up repeat high phase");
    step();                   check(8'hF3, 7, "nav up repeat low phase");
    send(8'hE0); send(8'h50); check(8'hF7, 7, "nav down overlap high phase");
    step();                   check(8'hF3, 7, "nav down overlap low phase");
    send(8'hE0); send(8'hC8); check(8'hFF, 10, "nav up release clears both");
    send(8'hE0); send(8'h50); check(8'hFB, 10, "nav down fresh press no pulse");
    step();                   check(8'hFB, 10, "nav down stays low");
    send(8'hE0); send(8'hD0); check(8'hFF, 3, "nav down release");

    // R10: release then press again acts as a fresh press
    send(8'h0F); check(8'hEF, 10, "btn A press");
    send(8'h8F); check(8'hFF, 10, "btn A release");
    send(8'h0F); check(8'hEF, 10, "btn A press again");
    send(8'h8F); check(8'hFF, 10, "btn A release again");

    // R1: reset mid-stream clears lines, held state and prefix flag
    send(8'h1C); check(8'hBF, 5, "btn C before reset");
    send(8'hE0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(8'hFF, 1, "lines released during reset");
    rst = 1'b0;
    send(8'h48); check(8'hFF, 1, "prefix flag cleared by reset");
    send(8'h1C); check(8'hBF, 1, "held state cleared by reset");
    send(8'h9C); check(8'hFF, 3, "btn C release after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: lines_n=%h expected=completion", lines_n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule